// File: doc/BRIEF.md
# Chien Search Bit Corrector

This block is the last stage of a serial decoder for a binary BCH code of length 15 with five information bits and three correctable errors. The field is GF(16). A load strobe hands over four error-locator coefficients. From then on the block tests one codeword position per clock for a root of the locator polynomial. In the same cycle it corrects the delayed received bit that arrives serially from the upstream buffer.

The search covers only the five highest positions (14 down to 10), which carry the information bits. Each corrected bit leaves on `dout`, and `vdout` marks the cycles in which `dout` holds a valid result. A new load restarts the search at position 14. The syndrome stage and the locator solver are not part of this block.

Top module: `chien_corrector`

## Requirements
- R1: While `rst` is high, and on the clock after it falls with no load applied, `vdout` and `dout` are both 0.
- R2: A high `load` at a rising edge captures `sigma_in`. Coefficient i occupies bits [4i+3:4i], so i=0 sits in the low nibble. Field elements are in polynomial basis with generator x^4+x+1 and alpha = 4'b0010.
- R3: After the load edge, `bit_in` in cycle j (j=0..4) is received position 14-j. It appears on `dout` after the next rising edge, inverted exactly when sigma(alpha^(j+1)) = 0, that is, when the locator has a root at alpha^-(14-j).
- R4: An error at any of positions 10..14 whose locator term is in sigma is corrected on `dout`. Errors at positions 0..9 leave the five output bits unchanged.
- R5: `vdout` is high on exactly the five rising edges after a load edge, and low from the sixth onward.
- R6: `dout` is 0 whenever `vdout` is 0.
- R7: A load while a search is running drops `vdout` at that edge. The search then restarts at position 14 with the new coefficients and gives five new valid bits.
- R8: When no search is running, `bit_in` has no effect: `dout` and `vdout` stay 0.
- R9: Scaling all four coefficients by the same nonzero field element does not change which bits are corrected.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Rising-edge clock |
| rst | input | 1 | Synchronous reset, active high |
| load | input | 1 | Start (or restart) a search with `sigma_in` |
| sigma_in | input | 16 | Four 4-bit locator coefficients, coefficient 0 in the low nibble |
| bit_in | input | 1 | Delayed received bit, highest position first |
| dout | output | 1 | Corrected information bit |
| vdout | output | 1 | High when `dout` holds a valid bit |

## Verification
A wrong coefficient register or a broken constant multiplier shows up as a missed or spurious inversion on `dout`. It appears at the first position whose root test depends on the bad value, so it is visible within five valid bits of the load. A fault in the position counter shows up at once as a valid window that is longer or shorter than five cycles, or as a window that survives a reload. Because error patterns include positions that are never output and coefficient sets that are scaled, a multiplier error that happens to keep the roots of unscaled locators is still exposed.

// File: rtl/chien_pkg.sv
package chien_pkg;
  localparam int GF_M = 4;
  localparam logic [GF_M:0] GF_POLY = 5'b10011;

  typedef logic [GF_M-1:0] gf_t;

  function automatic gf_t gf_xtime(gf_t a);
    gf_t sh;
    sh = {a[GF_M-2:0], 1'b0};
    return a[GF_M-1] ? (sh ^ GF_POLY[GF_M-1:0]) : sh;
  endfunction

  function automatic gf_t gf_mul(gf_t a, gf_t b);
    gf_t acc;
    acc = '0;
    for (int i = GF_M - 1; i >= 0; i--) begin
      acc = gf_xtime(acc) ^ (b[i] ? a : '0);
    end
    return acc;
  endfunction

  function automatic gf_t gf_alpha_pow(int e);
    gf_t r;
    r = gf_t'(1);
    for (int k = 0; k < e; k++) begin
      r = gf_xtime(r);
    end
    return r;
  endfunction
endpackage

// File: rtl/chien_cell.sv
module chien_cell
  import chien_pkg::*;
#(
  parameter int IDX = 0
) (
  input  logic clk,
  input  logic rst,
  input  logic load,
  input  logic step,
  input  gf_t  coef_in,
  output gf_t  term
);
  localparam gf_t MULT = gf_alpha_pow(IDX);

  always_ff @(posedge clk) begin
    if (rst) begin
      term <= '0;
    end else if (load) begin
      term <= gf_mul(coef_in, MULT);
    end else if (step) begin
      term <= gf_mul(term, MULT);
    end
  end
endmodule

// File: rtl/chien_seq.sv
module chien_seq #(
  parameter int K = 5
) (
  input  logic clk,
  input  logic rst,
  input  logic load,
  output logic active,
  output logic step
);
  localparam int CW = $clog2(K + 1);
  localparam logic [CW-1:0] START = CW'(K);

  logic [CW-1:0] remain;

  always_ff @(posedge clk) begin
    if (rst) begin
      remain <= '0;
    end else if (load) begin
      remain <= START;
    end else if (remain != '0) begin
      remain <= remain - 1'b1;
    end
  end

  assign active = (remain != '0);
  assign step   = active & ~load;
endmodule

// File: rtl/chien_out.sv
module chien_out (
  input  logic clk,
  input  logic rst,
  input  logic load,
  input  logic active,
  input  logic bit_in,
  input  logic root_hit,
  output logic dout,
  output logic vdout
);
  always_ff @(posedge clk) begin
    if (rst || load || !active) begin
      dout  <= 1'b0;
      vdout <= 1'b0;
    end else begin
      dout  <= bit_in ^ root_hit;
      vdout <= 1'b1;
    end
  end
endmodule

// File: rtl/chien_corrector.sv
module chien_corrector
  import chien_pkg::*;
#(
  parameter int T = 3,
  parameter int K = 5
) (
  input  logic                  clk,
  input  logic                  rst,
  input  logic                  load,
  input  logic [(T+1)*GF_M-1:0] sigma_in,
  input  logic                  bit_in,
  output logic                  dout,
  output logic                  vdout
);
  gf_t  terms [T+1];
  gf_t  eval_sum;
  logic search_active;
  logic search_step;
  logic root_hit;

  chien_seq #(.K(K)) u_seq (
    .clk    (clk),
    .rst    (rst),
    .load   (load),
    .active (search_active),
    .step   (search_step)
  );

  for (genvar g = 0; g <= T; g++) begin : g_cell
    chien_cell #(.IDX(g)) u_cell (
      .clk     (clk),
      .rst     (rst),
      .load    (load),
      .step    (search_step),
      .coef_in (sigma_in[g*GF_M +: GF_M]),
      .term    (terms[g])
    );
  end

  always_comb begin
    eval_sum = '0;
    for (int i = 0; i <= T; i++) begin
      eval_sum = eval_sum ^ terms[i];
    end
  end

  assign root_hit = (eval_sum == '0);

  chien_out u_out (
    .clk      (clk),
    .rst      (rst),
    .load     (load),
    .active   (search_active),
    .bit_in   (bit_in),
    .root_hit (root_hit),
    .dout     (dout),
    .vdout    (vdout)
  );
endmodule

// File: rtl/chien_corrector_chk.sv
module chien_corrector_chk #(
  parameter int K = 5
) (
  input logic clk,
  input logic rst,
  input logic load,
  input logic search_active,
  input logic root_hit,
  input logic bit_in,
  input logic dout,
  input logic vdout
);
  int unsigned run_len;

  always_ff @(posedge clk) begin
    if (rst || !vdout) begin
      run_len <= 0;
    end else if (run_len <= K) begin
      run_len <= run_len + 1;
    end
  end

  // R5
  valid_needs_search_chk: assert property (@(posedge clk) disable iff (rst)
    vdout |-> ($past(search_active) && !$past(load)));

  // R5
  valid_run_bound_chk: assert property (@(posedge clk) disable iff (rst)
    run_len <= K);

  // R6
  idle_dout_zero_chk: assert property (@(posedge clk) disable iff (rst)
    !vdout |-> !dout);

  // R7
  load_starts_search_chk: assert property (@(posedge clk) disable iff (rst)
    load |=> (search_active && !vdout));

  // R3
  corrected_bit_chk: assert property (@(posedge clk) disable iff (rst)
    vdout |-> (dout == ($past(bit_in) ^ $past(root_hit))));
endmodule

bind chien_corrector chien_corrector_chk #(.K(K)) u_chk (
  .clk           (clk),
  .rst           (rst),
  .load          (load),
  .search_active (search_active),
  .root_hit      (root_hit),
  .bit_in        (bit_in),
  .dout          (dout),
  .vdout         (vdout)
);

// File: tb/chien_corrector_test.sv
module chien_corrector_test;
  logic clk = 1'b0;
  logic rst = 1'b1;
  logic load = 1'b0;
  logic [15:0] sigma_in = '0;
  logic bit_in = 1'b0;
  logic dout, vdout;
  int checks = 0;
  int fails = 0;
  logic [3:0] exp_tab [15];
  int log_tab [16];

  always #4 clk = ~clk;

  chien_corrector uut (
    .clk(clk), .rst(rst), .load(load), .sigma_in(sigma_in),
    .bit_in(bit_in), .dout(dout), .vdout(vdout)
  );

  // {scale exponent, error positions 14..0, received bits of positions 14..10}
  localparam int NV = 8;
  localparam logic [23:0] VEC [NV] = '{
    {4'd0, 15'h0000, 5'b10101},
    {4'd0, 15'h4000, 5'b00101},
    {4'd0, 15'h1000, 5'b10001},
    {4'd3, 15'h4400, 5'b00100},
    {4'd0, 15'h2C00, 5'b11010},
    {4'd7, 15'h0009, 5'b00010},
    {4'd0, 15'h4022, 5'b01110},
    {4'd11, 15'h1880, 5'b11011}
  };

  function automatic logic [3:0] fmul(logic [3:0] a, logic [3:0] b);
    if (a == 0 || b == 0) return 4'd0;
    return exp_tab[(log_tab[a] + log_tab[b]) % 15];
  endfunction

  function automatic logic [15:0] build_sigma(logic [14:0] errs, int scale);
    logic [3:0] s [4];
    logic [15:0] packed_s;
    s[0] = 4'd1; s[1] = 0; s[2] = 0; s[3] = 0;
    for (int p = 0; p < 15; p++) begin
      if (errs[p]) begin
        for (int i = 3; i >= 1; i--) s[i] = s[i] ^ fmul(exp_tab[p], s[i-1]);
      end
    end
    for (int i = 0; i < 4; i++) packed_s[i*4 +: 4] = fmul(s[i], exp_tab[scale]);
    return packed_s;
  endfunction

  task automatic check(input logic act, input logic expv, input string what);
    checks++;
    if (act !== expv) begin
      fails++;
      $display("FAIL %s: got %b expected %b", what, act, expv);
    end
  endtask

  task automatic do_load(input logic [15:0] s);
    @(negedge clk);
    load = 1'b1; sigma_in = s;
    @(negedge clk);
    load = 1'b0;
  endtask

  // feeds positions 14..10 starting right after a load edge, checks each output
  task automatic feed_word(input logic [4:0] rx, input logic [14:0] errs, input string tag);
    for (int j = 0; j < 5; j++) begin
      bit_in = rx[4-j];
      @(negedge clk);
      check(vdout, 1'b1, $sformatf("R5 vdout pos %0d %s", 14-j, tag));
      check(dout, rx[4-j] ^ errs[14-j], $sformatf("R3/R4 dout pos %0d %s", 14-j, tag));
    end
    bit_in = 1'b1;
    @(negedge clk);
    check(vdout, 1'b0, {"R5 vdout after five bits ", tag});
    check(dout, 1'b0, {"R6 dout idle ", tag});
  endtask

  initial begin
    exp_tab[0] = 4'd1;
    for (int i = 1; i < 15; i++)
      exp_tab[i] = exp_tab[i-1][3] ? ({exp_tab[i-1][2:0], 1'b0} ^ 4'b0011) : {exp_tab[i-1][2:0], 1'b0};
    log_tab[0] = 0;
    for (int i = 0; i < 15; i++) log_tab[exp_tab[i]] = i;

    repeat (3) @(negedge clk);
    check(vdout, 1'b0, "R1 vdout in reset");
    check(dout, 1'b0, "R1 dout in reset");
    rst = 1'b0;
    @(negedge clk);
    check(vdout, 1'b0, "R1 vdout after reset");

    // R2 R3 R4 R9: table walk
    for (int v = 0; v < NV; v++) begin
      do_load(build_sigma(VEC[v][19:5], int'(VEC[v][23:20])));
      feed_word(VEC[v][4:0], VEC[v][19:5], $sformatf("vector %0d", v));
    end

    // R8: bit_in toggles while idle
    for (int k = 0; k < 6; k++) begin
      bit_in = k[0];
      @(negedge clk);
      check(vdout, 1'b0, "R8 vdout idle");
      check(dout, 1'b0, "R8 dout idle");
    end

    // R7: reload after two bits
    @(negedge clk);
    load = 1'b1; sigma_in = build_sigma(15'h4000, 0);
    @(negedge clk);
    load = 1'b0; bit_in = 1'b1;
    @(negedge clk);
    bit_in = 1'b0;
    @(negedge clk);
    check(vdout, 1'b1, "R7 first search running");
    load = 1'b1; sigma_in = build_sigma(15'h2400, 0);
    @(negedge clk);
    check(vdout, 1'b0, "R7 vdout drops on reload");
    check(dout, 1'b0, "R7 dout zero on reload");
    load = 1'b0;
    feed_word(5'b10111, 15'h2400, "R7 restarted");

    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end

  initial begin
    #(8 * 50000);
    fails++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end
endmodule